// File: doc/BRIEF.md
# Big-Endian Sub-Word Load/Store Unit

This block carries out one data-memory access of a 32-bit big-endian processor at a time. The caller presents an opcode, the effective address (base plus sign-extended offset, already summed), the index and old value of the target register, and a start strobe. The block reads the aligned word that holds the addressed bytes. For a load it extracts, extends or merges the value for register writeback. For a store it merges the new bytes into the word it read and writes the whole word back to the same aligned address.

Byte lanes are counted from the most significant end: lane 0 is bits 31..24 and lane 3 is bits 7..0. The two low address bits pick the lane. The unaligned left and right forms (load-left, load-right, store-left, store-right) are built from a single aligned word by shifting and masking. A pair of them, issued with the two ends of an unaligned word, assembles or scatters that word.

The memory side is a request/busy handshake. A request stays high and unchanged until an edge where busy is low. At that edge a read returns its data on `mem_rdata`, or a write is taken.

Top module: `be_subword_lsu`

## Requirements
- R1: Both the read and the write of an access use the effective address with bits 1..0 cleared, and both phases use the same address.
- R2: Opcode 0x20 returns lane `eff_addr[1:0]` of the word, sign-extended. Opcode 0x24 returns the same lane zero-extended.
- R3: Opcode 0x21 returns lanes {2h, 2h+1}, where h = `eff_addr[1]`, sign-extended. Opcode 0x25 returns the same lanes zero-extended. Address bit 0 has no effect on either.
- R4: Opcode 0x22 (load-left) with offset o writes the word shifted left by 8*o. Bits below 8*o keep the old register value.
- R5: Opcode 0x26 (load-right) with offset o writes the word shifted right by 24-8*o. Bits above 32-(24-8*o) keep the old register value.
- R6: Opcode 0x28 puts register lane 3 into memory lane o. Opcode 0x29 puts register lanes 2..3 into memory lanes 2h..2h+1. All other memory lanes keep their old contents.
- R7: Opcode 0x2a (store-left) writes the register shifted right by 8*o into the lanes o..3. Opcode 0x2e (store-right) writes the register shifted left by 24-8*o into the lanes 0..o. Other lanes are kept.
- R8: Opcodes 0x2b and 0x38 store the register value unchanged. Opcode 0x38 also writes back the constant 1. The other stores write back nothing.
- R9: Opcodes 0x23 and 0x30 return the whole word and make no memory write.
- R10: Each accepted start issues exactly one read, then one write for store opcodes only. A request is held stable while busy is high. `done` pulses for one cycle after the last phase. Start is ignored until that pulse has ended.
- R11: Any other opcode raises `bad_op` together with `done`, issues no memory request and writes back nothing.
- R12: Writeback is never signalled for register index 0.
- R13: After reset, requests, `done`, `wb_en` and `bad_op` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an access (taken only when idle) |
| op_code | input | OPW | Access opcode |
| eff_addr | input | XLEN | Effective byte address |
| rt_idx | input | RIDX | Target register index |
| rt_old | input | XLEN | Old value of the target register |
| mem_rd_req | output | 1 | Word read request |
| mem_wr_req | output | 1 | Word write request |
| mem_addr | output | XLEN | Aligned word address |
| mem_wdata | output | XLEN | Merged word to write |
| mem_rdata | input | XLEN | Read data, valid at the accepting edge |
| mem_busy | input | 1 | Memory stalls the current request |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | Register writeback, valid with done |
| wb_idx | output | RIDX | Writeback register index |
| wb_data | output | XLEN | Writeback value |
| bad_op | output | 1 | Unsupported opcode, valid with done |

## Verification
Every opcode is tried at all four offsets with distinct byte values in each lane. This separates a lane swap from a wrong shift amount and shows whether sign or zero extension was applied. Old register contents differ from memory in every byte, which shows whether the unaligned forms keep the correct side. Random accesses mix all opcodes, offsets, register indices including 0, and random busy stalls, and check the handshake hold and the single write. A directed case raises a second start while a read is stalled. Another sends unsupported opcodes and confirms there is no memory traffic.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam logic [5:0] OPC_LB  = 6'h20;
  localparam logic [5:0] OPC_LH  = 6'h21;
  localparam logic [5:0] OPC_LWL = 6'h22;
  localparam logic [5:0] OPC_LW  = 6'h23;
  localparam logic [5:0] OPC_LBU = 6'h24;
  localparam logic [5:0] OPC_LHU = 6'h25;
  localparam logic [5:0] OPC_LWR = 6'h26;
  localparam logic [5:0] OPC_SB  = 6'h28;
  localparam logic [5:0] OPC_SH  = 6'h29;
  localparam logic [5:0] OPC_SWL = 6'h2a;
  localparam logic [5:0] OPC_SW  = 6'h2b;
  localparam logic [5:0] OPC_SWR = 6'h2e;
  localparam logic [5:0] OPC_LL  = 6'h30;
  localparam logic [5:0] OPC_SC  = 6'h38;

  typedef enum logic [3:0] {
    K_BAD, K_LB, K_LBU, K_LH, K_LHU, K_LWL, K_LWR, K_LW,
    K_LL, K_SB, K_SH, K_SWL, K_SWR, K_SW, K_SC
  } acc_kind_t;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_DONE} seq_st_t;
endpackage

// File: rtl/lsm_decode.sv
module lsm_decode
  import lsm_pkg::*;
#(
  parameter int OPW = 6
) (
  input  logic [OPW-1:0] op,
  output acc_kind_t      kind,
  output logic           valid,
  output logic           is_store,
  output logic           writes_reg
);
  always_comb begin
    case (6'(op))
      OPC_LB:  kind = K_LB;
      OPC_LBU: kind = K_LBU;
      OPC_LH:  kind = K_LH;
      OPC_LHU: kind = K_LHU;
      OPC_LWL: kind = K_LWL;
      OPC_LWR: kind = K_LWR;
      OPC_LW:  kind = K_LW;
      OPC_LL:  kind = K_LL;
      OPC_SB:  kind = K_SB;
      OPC_SH:  kind = K_SH;
      OPC_SWL: kind = K_SWL;
      OPC_SWR: kind = K_SWR;
      OPC_SW:  kind = K_SW;
      OPC_SC:  kind = K_SC;
      default: kind = K_BAD;
    endcase
  end

  always_comb begin
    valid    = (kind != K_BAD);
    is_store = (kind == K_SB) || (kind == K_SH) || (kind == K_SWL) ||
               (kind == K_SWR) || (kind == K_SW) || (kind == K_SC);
    writes_reg = valid && (!is_store || kind == K_SC);
  end
endmodule

// File: rtl/lsm_lane.sv
module lsm_lane
  import lsm_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  acc_kind_t       kind,
  input  logic [1:0]      off,
  input  logic [XLEN-1:0] mem_word,
  input  logic [XLEN-1:0] reg_word,
  output logic [XLEN-1:0] load_val,
  output logic [XLEN-1:0] store_val
);
  localparam int SHW = $clog2(XLEN);
  localparam int BW  = 8;
  localparam int HW  = 16;

  logic [SHW-1:0]  sh_byte, sh_half, sh_left;
  logic [BW-1:0]   byte_v;
  logic [HW-1:0]   half_v;
  logic [XLEN-1:0] ones, m_left, m_right;

  always_comb begin
    sh_byte = SHW'({~off, 3'b000});
    sh_half = SHW'({~off[1], 4'b0000});
    sh_left = SHW'({off, 3'b000});
    ones    = '1;
    byte_v  = BW'(mem_word >> sh_byte);
    half_v  = HW'(mem_word >> sh_half);
    m_left  = ones << sh_left;
    m_right = ones >> sh_byte;
  end

  always_comb begin
    case (kind)
      K_LB:    load_val = {{(XLEN-BW){byte_v[BW-1]}}, byte_v};
      K_LBU:   load_val = {{(XLEN-BW){1'b0}}, byte_v};
      K_LH:    load_val = {{(XLEN-HW){half_v[HW-1]}}, half_v};
      K_LHU:   load_val = {{(XLEN-HW){1'b0}}, half_v};
      K_LWL:   load_val = (mem_word << sh_left) | (reg_word & ~m_left);
      K_LWR:   load_val = (mem_word >> sh_byte) | (reg_word & ~m_right);
      default: load_val = mem_word;
    endcase
  end

  always_comb begin
    case (kind)
      K_SB: store_val = (mem_word & ~(XLEN'({BW{1'b1}}) << sh_byte)) |
                        (XLEN'(reg_word[BW-1:0]) << sh_byte);
      K_SH: store_val = (mem_word & ~(XLEN'({HW{1'b1}}) << sh_half)) |
                        (XLEN'(reg_word[HW-1:0]) << sh_half);
      K_SWL: store_val = (mem_word & ~(ones >> sh_left)) | (reg_word >> sh_left);
      K_SWR: store_val = (mem_word & ~(ones << sh_byte)) | (reg_word << sh_byte);
      K_SW, K_SC: store_val = reg_word;
      default: store_val = mem_word;
    endcase
  end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
  import lsm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic op_valid,
  input  logic store_q,
  input  logic mem_busy,
  output logic capture,
  output logic rd_req,
  output logic wr_req,
  output logic rd_fire,
  output logic done
);
  seq_st_t st, st_nx;

  always_comb begin
    capture = (st == ST_IDLE) && start;
    rd_req  = (st == ST_READ);
    wr_req  = (st == ST_WRITE);
    done    = (st == ST_DONE);
    rd_fire = rd_req && !mem_busy;
  end

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (start) st_nx = op_valid ? ST_READ : ST_DONE;
      ST_READ:  if (!mem_busy) st_nx = store_q ? ST_WRITE : ST_DONE;
      ST_WRITE: if (!mem_busy) st_nx = ST_DONE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_req_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));
  p_wr_after_rd_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_req) |-> $past(rd_req && !mem_busy));
endmodule

// File: rtl/be_subword_lsu.sv
module be_subword_lsu
  import lsm_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OPW  = 6,
  parameter int RIDX = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [OPW-1:0]  op_code,
  input  logic [XLEN-1:0] eff_addr,
  input  logic [RIDX-1:0] rt_idx,
  input  logic [XLEN-1:0] rt_old,
  output logic            mem_rd_req,
  output logic            mem_wr_req,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_busy,
  output logic            done,
  output logic            wb_en,
  output logic [RIDX-1:0] wb_idx,
  output logic [XLEN-1:0] wb_data,
  output logic            bad_op
);
  localparam int OFFW = 2;

  acc_kind_t kind_d, kind_q;
  logic valid_d, store_d, wreg_d;
  logic capture, rd_fire, seq_done;
  logic store_q, wbk_q, bad_q;
  logic [OFFW-1:0] off_q;
  logic [XLEN-1:0] addr_q, rt_q, wdata_q, wbd_q, load_v, store_v;
  logic [RIDX-1:0] rtn_q;

  lsm_decode #(.OPW(OPW)) dec_i (
    .op(op_code), .kind(kind_d), .valid(valid_d),
    .is_store(store_d), .writes_reg(wreg_d)
  );

  lsm_lane #(.XLEN(XLEN)) lane_i (
    .kind(kind_q), .off(off_q), .mem_word(mem_rdata), .reg_word(rt_q),
    .load_val(load_v), .store_val(store_v)
  );

  lsm_seq seq_i (
    .clk(clk), .rst(rst), .start(start), .op_valid(valid_d),
    .store_q(store_q), .mem_busy(mem_busy), .capture(capture),
    .rd_req(mem_rd_req), .wr_req(mem_wr_req), .rd_fire(rd_fire),
    .done(seq_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q  <= K_BAD;
      off_q   <= '0;
      addr_q  <= '0;
      rt_q    <= '0;
      rtn_q   <= '0;
      store_q <= 1'b0;
      wbk_q   <= 1'b0;
      bad_q   <= 1'b0;
      wdata_q <= '0;
      wbd_q   <= '0;
    end else begin
      if (capture) begin
        kind_q  <= kind_d;
        off_q   <= eff_addr[OFFW-1:0];
        addr_q  <= {eff_addr[XLEN-1:OFFW], {OFFW{1'b0}}};
        rt_q    <= rt_old;
        rtn_q   <= rt_idx;
        store_q <= store_d;
        wbk_q   <= wreg_d && (rt_idx != '0);
        bad_q   <= !valid_d;
      end
      if (rd_fire) begin
        wdata_q <= store_v;
        wbd_q   <= (kind_q == K_SC) ? XLEN'(1) : load_v;
      end
    end
  end

  always_comb begin
    mem_addr  = addr_q;
    mem_wdata = wdata_q;
    done      = seq_done;
    wb_en     = seq_done && wbk_q;
    wb_idx    = rtn_q;
    wb_data   = wbd_q;
    bad_op    = seq_done && bad_q;
  end

  p_same_addr_r1: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req |-> mem_addr == $past(mem_addr));
  p_hold_rd_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && mem_busy) |=> mem_rd_req && $stable(mem_addr));
  p_hold_wr_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_req && mem_busy) |=> mem_wr_req && $stable(mem_wdata));
  p_bad_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    bad_op |-> !wb_en);
  p_zero_dst_r12: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> wb_idx != '0);
endmodule

// File: tb/be_subword_lsu_tb_top.sv
`timescale 1ns/1ps
module be_subword_lsu_tb_top;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [5:0]  op_code = '0;
  logic [31:0] eff_addr = '0, rt_old = '0;
  logic [4:0]  rt_idx = '0;
  logic mem_rd_req, mem_wr_req, done, wb_en, bad_op;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, wb_data;
  logic [4:0]  wb_idx;
  logic mem_busy = 1'b0;

  logic [31:0] mem_arr [64];
  int total = 0, bad = 0, rd_cnt = 0, wr_cnt = 0, addr_err = 0;
  logic [31:0] exp_addr = '0;
  logic force_busy = 1'b0, rb_en = 1'b0;

  always #4 clk = ~clk;

  be_subword_lsu dut_i (
    .clk(clk), .rst(rst), .start(start), .op_code(op_code), .eff_addr(eff_addr),
    .rt_idx(rt_idx), .rt_old(rt_old), .mem_rd_req(mem_rd_req),
    .mem_wr_req(mem_wr_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_busy(mem_busy), .done(done), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_data(wb_data), .bad_op(bad_op)
  );

  assign mem_rdata = mem_arr[mem_addr[7:2]];

  always @(posedge clk) begin
    if (!rst && !mem_busy && (mem_rd_req || mem_wr_req)) begin
      if (mem_addr != exp_addr) addr_err++;
      if (mem_rd_req) rd_cnt++;
      if (mem_wr_req) begin
        wr_cnt++;
        mem_arr[mem_addr[7:2]] <= mem_wdata;
      end
    end
  end

  always @(negedge clk) mem_busy <= force_busy || (rb_en && ($urandom % 3 == 0));

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] lane(logic [31:0] w, int k);
    return w[31-8*k -: 8];
  endfunction
  function automatic logic [31:0] put(logic [31:0] w, int k, logic [7:0] b);
    logic [31:0] r = w;
    r[31-8*k -: 8] = b;
    return r;
  endfunction

  function automatic bit op_ok(logic [5:0] op);
    return op inside {6'h20,6'h21,6'h22,6'h23,6'h24,6'h25,6'h26,
                      6'h28,6'h29,6'h2a,6'h2b,6'h2e,6'h30,6'h38};
  endfunction
  function automatic bit op_st(logic [5:0] op);
    return op inside {6'h28,6'h29,6'h2a,6'h2b,6'h2e,6'h38};
  endfunction
  function automatic string tag_of(logic [5:0] op);
    case (op)
      6'h20, 6'h24: return "R2";
      6'h21, 6'h25: return "R3";
      6'h22: return "R4";
      6'h26: return "R5";
      6'h28, 6'h29: return "R6";
      6'h2a, 6'h2e: return "R7";
      6'h2b, 6'h38: return "R8";
      6'h23, 6'h30: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] ref_load(logic [5:0] op, int o, logic [31:0] m,
                                          logic [31:0] rt);
    logic [31:0] r = rt;
    int h = (o / 2) * 2;
    case (op)
      6'h20: r = {{24{m[31-8*o]}}, lane(m, o)};
      6'h24: r = {24'h0, lane(m, o)};
      6'h21: r = {{16{m[31-8*h]}}, lane(m, h), lane(m, h+1)};
      6'h25: r = {16'h0, lane(m, h), lane(m, h+1)};
      6'h22: for (int j = 0; j < 4; j++) if (j + o <= 3) r = put(r, j, lane(m, j+o));
      6'h26: for (int j = 0; j < 4; j++) if (j >= 3 - o) r = put(r, j, lane(m, j-(3-o)));
      6'h38: r = 32'd1;
      default: r = m;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] ref_store(logic [5:0] op, int o, logic [31:0] m,
                                           logic [31:0] rt);
    logic [31:0] r = m;
    int h = (o / 2) * 2;
    case (op)
      6'h28: r = put(m, o, lane(rt, 3));
      6'h29: r = put(put(m, h, lane(rt, 2)), h+1, lane(rt, 3));
      6'h2a: for (int j = 0; j < 4; j++) if (j >= o) r = put(r, j, lane(rt, j-o));
      6'h2e: for (int j = 0; j < 4; j++) if (j <= o) r = put(r, j, lane(rt, j+3-o));
      6'h2b, 6'h38: r = rt;
      default: r = m;
    endcase
    return r;
  endfunction

  task automatic run_op(input logic [5:0] op, input logic [31:0] ea,
                        input logic [4:0] rn, input logic [31:0] rv, input bit poke);
    int n = 0;
    int o = int'(ea[1:0]);
    logic [5:0] idx = ea[7:2];
    logic [31:0] m0 = mem_arr[idx];
    bit vld = op_ok(op), st = op_st(op);
    bit exp_wb = vld && (!st || op == 6'h38) && (rn != 0);
    logic [31:0] exp_wd = ref_load(op, o, m0, rv);
    logic [31:0] exp_m = vld ? ref_store(op, o, m0, rv) : m0;
    int rd0 = rd_cnt, wr0 = wr_cnt;
    string tg = tag_of(op);
    exp_addr = {ea[31:2], 2'b00};
    addr_err = 0;
    if (poke) force_busy = 1'b1;
    @(negedge clk);
    op_code = op; eff_addr = ea; rt_idx = rn; rt_old = rv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 60) begin
      if (poke && n == 1) begin
        start = 1'b1; op_code = 6'h00; eff_addr = ~ea; rt_idx = 5'd7; rt_old = 32'h0;
      end
      if (poke && n == 2) start = 1'b0;
      if (poke && n == 3) force_busy = 1'b0;
      @(negedge clk);
      n++;
    end
    check(n < 60, "R10 watchdog", 32'(n), 32'd60);
    check(bad_op == !vld, "R11 bad_op", 32'(bad_op), 32'(!vld));
    check(wb_en == exp_wb, (rn == 0) ? "R12 wb_en" : {tg, " wb_en"}, 32'(wb_en), 32'(exp_wb));
    if (exp_wb) begin
      check(wb_data == exp_wd, {tg, " wb_data"}, wb_data, exp_wd);
      check(wb_idx == rn, {tg, " wb_idx"}, 32'(wb_idx), 32'(rn));
    end
    check(mem_arr[idx] == exp_m, {tg, " memory"}, mem_arr[idx], exp_m);
    check(wr_cnt - wr0 == ((vld && st) ? 1 : 0), "R10 write count",
          32'(wr_cnt - wr0), 32'((vld && st) ? 1 : 0));
    check(rd_cnt - rd0 == (vld ? 1 : 0), vld ? "R10 read count" : "R11 read count",
          32'(rd_cnt - rd0), 32'(vld ? 1 : 0));
    check(addr_err == 0, "R1 address", 32'(addr_err), 32'd0);
    @(negedge clk);
    check(!done, "R10 done pulse", 32'(done), 32'd0);
  endtask

  initial begin
    logic [5:0] ops [14] = '{6'h20,6'h21,6'h22,6'h23,6'h24,6'h25,6'h26,
                             6'h28,6'h29,6'h2a,6'h2b,6'h2e,6'h30,6'h38};
    void'($urandom(32'd4021));
    for (int i = 0; i < 64; i++) mem_arr[i] = $urandom;
    repeat (3) @(negedge clk);
    check(!mem_rd_req && !mem_wr_req && !done && !wb_en && !bad_op, "R13 reset",
          {27'b0, mem_rd_req, mem_wr_req, done, wb_en, bad_op}, 32'd0);
    rst = 1'b0;
    for (int k = 0; k < 14; k++)
      for (int o = 0; o < 4; o++) begin
        mem_arr[5] = 32'h8A9BC4D5;
        run_op(ops[k], {24'h00ABCD, 6'd5, 2'(o)}, 5'd9, 32'h1E2F3A4B, 1'b0);
      end
    run_op(6'h38, 32'h0000_0010, 5'd0, 32'h5555_AAAA, 1'b0);
    run_op(6'h23, 32'h0000_0020, 5'd0, 32'h0, 1'b0);
    run_op(6'h27, 32'h0000_0030, 5'd4, 32'h1, 1'b0);
    run_op(6'h00, 32'h0000_0031, 5'd4, 32'h1, 1'b0);
    run_op(6'h2c, 32'h0000_0032, 5'd4, 32'h1, 1'b0);
    run_op(6'h21, 32'h0000_0043, 5'd3, 32'h0, 1'b1);
    run_op(6'h2e, 32'h0000_0045, 5'd3, 32'hCAFE_F00D, 1'b1);
    rb_en = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [5:0] op = ($urandom % 10 == 0) ? 6'($urandom) : ops[$urandom % 14];
      run_op(op, $urandom, 5'($urandom), $urandom, 1'b0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule